// File: doc/BRIEF.md
# PCI Configuration Access Port

This block gives a processor-facing I/O slave indirect access to the configuration space of a single-segment PCI host bridge. It holds two 32-bit registers. A 32-bit address register selects a device and a dword register. A data window then forwards reads and writes to whatever that address selects. Accesses are 1, 2 or 4 bytes wide and may start at any byte offset in the 8-byte range. Bytes are packed little-endian, with the first byte on lane 0 of the data bus.

Only bus 0 is decoded. Device 0 is the bridge's own configuration register file, which is held inside this block. Device k (k at least 1) is endpoint slot k-1, which is reached through a per-slot write strobe and a per-slot 32-bit read bus. Any miss reads as all ones, and a write that misses has no effect. Each slot also gets a fixed legacy interrupt pin assignment.

Top module: `cfg_access_port`

## Requirements
- R1: After reset the address register is zero, io_rvalid is low, and a data-window read returns 0xFFFFFFFF.
- R2: Offsets 0-3 reach the address register and offsets 4-7 reach the data window. Any larger offset reads as 0xFFFFFFFF before lane extraction, and a write to it changes nothing.
- R3: A write to the address register replaces only the byte lanes (offset mod 4) up to (offset mod 4 + size - 1), taking io_wdata bytes from lane 0 upward. A 4-byte write at offset 0 replaces the whole register.
- R4: A write whose size is not 1, 2 or 4, or whose (offset mod 4) + size exceeds 4, is ignored.
- R5: A read returns the selected 32-bit value shifted down by 8*(offset mod 4), with the lanes above size cleared. A read with a bad size or one that crosses the 4-byte boundary returns 0xFFFFFFFF.
- R6: When address bit 31 (enable) is clear, or bits 23:16 (bus) are nonzero, a window read returns 0xFFFFFFFF and a window write reaches no target.
- R7: Device number (bits 15:11) 0 selects the bridge registers. Dword 0 reads {DEV_ID, VEND_ID}. Dword 2 reads class 0x06 in bits 31:24, subclass 0x00 in bits 23:16 and REV_ID in bits 7:0. Dword 3 reads header type 0x01 in bits 23:16. Writes to dwords 0, 2 and 3 are dropped.
- R8: Bridge dword 1 bits 15:0 are a command register in which only the bits set in CMD_WMASK are writable, and bits 31:16 read as 0. Bridge dwords 4-63 hold whatever is written to them, byte lane by byte lane.
- R9: A window write to device k, with slot k-1 populated, raises only sl_wr[k-1] in the same cycle. During that cycle sl_reg carries address bits 7:2, sl_be carries the written lanes, and sl_wdata carries the data shifted to those lanes. Reads of that slot return sl_rdata slice k-1.
- R10: A device number whose slot is unpopulated or beyond N_SLOTS reads 0xFFFFFFFF and raises no strobe.
- R11: The function number (bits 10:8) does not affect which target is selected.
- R12: io_rvalid is high in exactly the cycle after a read request, and never after a write or an idle cycle.
- R13: sl_int_pin slice i holds i mod 4 (0 = INTA, 1 = INTB, 2 = INTC, 3 = INTD).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | Access request, one cycle per access |
| io_we | input | 1 | 1 = write, 0 = read |
| io_ofs | input | OFS_W | Byte offset of the access |
| io_size | input | 3 | Access size in bytes (1, 2 or 4 are valid) |
| io_wdata | input | 32 | Write data, first byte on bits 7:0 |
| io_rdata | output | 32 | Registered read data |
| io_rvalid | output | 1 | Read data valid, one cycle after the request |
| sl_wr | output | N_SLOTS | One-hot per-slot write strobe |
| sl_reg | output | 6 | Dword register number for the slots |
| sl_be | output | 4 | Byte enables of the slot write |
| sl_wdata | output | 32 | Lane-aligned slot write data |
| sl_rdata | input | 32*N_SLOTS | Per-slot register read data for sl_reg |
| sl_present | input | N_SLOTS | Slot populated flags |
| sl_int_pin | output | 2*N_SLOTS | Per-slot interrupt pin code |

## Verification
The address register is built up from single-byte, half-word and full-word writes at every legal lane. This separates a correct lane merge from a shift that is computed in the wrong units. The same patterns are then repeated with lane-crossing and odd sizes, which must leave the register untouched. Window accesses sweep device 0, several populated slots, an empty slot, a slot number beyond the slot count, a nonzero bus, a cleared enable bit and a nonzero function number. A write to one slot followed by a read of its neighbour shows whether the strobes are routed to the right slot. Partial writes to the bridge's command and storage dwords separate the masked register from the plain storage and from the read-only identity words.

// File: rtl/cfgp_pkg.sv
`timescale 1ns/1ps
package cfgp_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned REG_W  = 6;
  localparam int unsigned DEV_W  = 5;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned PIN_W  = 2;

  // field positions inside the address register
  localparam int unsigned EN_BIT  = 31;
  localparam int unsigned BUS_LSB = 16;
  localparam int unsigned DEV_LSB = 11;
  localparam int unsigned REG_LSB = 2;

  localparam logic [WORD_W-1:0] ALL_ONES = '1;

  localparam logic [7:0] CLASS_BRIDGE = 8'h06;
  localparam logic [7:0] SUB_HOST     = 8'h00;
  localparam logic [7:0] HDR_BRIDGE   = 8'h01;

  function automatic logic [WORD_W-1:0] lanes_to_bits(input logic [LANES-1:0] be);
    logic [WORD_W-1:0] m;
    for (int b = 0; b < int'(LANES); b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction
endpackage

// File: rtl/cfgp_lane_ctl.sv
`timescale 1ns/1ps
module cfgp_lane_ctl
  import cfgp_pkg::*;
(
  input  logic [1:0]       start,
  input  logic [2:0]       size,
  output logic             ok,
  output logic [LANES-1:0] be,
  output logic [LANES-1:0] span
);
  logic [LANES-1:0] base;
  logic             size_ok;
  logic [3:0]       last;

  always_comb begin
    size_ok = 1'b1;
    case (size)
      3'd1:    base = LANES'(1);
      3'd2:    base = LANES'(3);
      3'd4:    base = '1;
      default: begin base = '0; size_ok = 1'b0; end
    endcase
    last = {2'b00, start} + {1'b0, size};
    ok   = size_ok && (last <= 4'd4);
    be   = ok ? (base << start) : '0;
    span = ok ? base : '0;
  end
endmodule

// File: rtl/cfgp_addr_reg.sv
`timescale 1ns/1ps
module cfgp_addr_reg
  import cfgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [LANES-1:0]  be,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr) begin
      for (int b = 0; b < int'(LANES); b++)
        if (be[b]) q[b*8 +: 8] <= wdata[b*8 +: 8];
    end
  end
endmodule

// File: rtl/cfgp_bridge_regs.sv
`timescale 1ns/1ps
module cfgp_bridge_regs
  import cfgp_pkg::*;
#(
  parameter logic [15:0] VEND_ID   = 16'h5A5A,
  parameter logic [15:0] DEV_ID    = 16'hC0DE,
  parameter logic [7:0]  REV_ID    = 8'h03,
  parameter logic [15:0] CMD_WMASK = 16'h0547
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [REG_W-1:0]  regn,
  input  logic [LANES-1:0]  be,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int unsigned DEPTH     = 1 << REG_W;
  localparam int unsigned FIRST_RAM = 4;
  localparam int unsigned CMD_LANES = 2;

  logic [15:0]       cmd_q;
  logic [WORD_W-1:0] ram [DEPTH];
  logic              ram_hit;

  assign ram_hit = (regn >= REG_W'(FIRST_RAM));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
    end else if (wr && regn == REG_W'(1)) begin
      for (int b = 0; b < int'(CMD_LANES); b++)
        if (be[b]) cmd_q[b*8 +: 8] <= wdata[b*8 +: 8] & CMD_WMASK[b*8 +: 8];
    end
  end

  // plain storage, no reset, byte-lane write
  always_ff @(posedge clk) begin
    if (wr && ram_hit) begin
      for (int b = 0; b < int'(LANES); b++)
        if (be[b]) ram[regn][b*8 +: 8] <= wdata[b*8 +: 8];
    end
  end

  always_comb begin
    case (regn)
      REG_W'(0): rdata = {DEV_ID, VEND_ID};
      REG_W'(1): rdata = {16'h0000, cmd_q};
      REG_W'(2): rdata = {CLASS_BRIDGE, SUB_HOST, 8'h00, REV_ID};
      REG_W'(3): rdata = {8'h00, HDR_BRIDGE, 8'h00, 8'h00};
      default:   rdata = ram[regn];
    endcase
  end
endmodule

// File: rtl/cfg_access_port.sv
`timescale 1ns/1ps
module cfg_access_port
  import cfgp_pkg::*;
#(
  parameter int unsigned N_SLOTS   = 4,
  parameter int unsigned OFS_W     = 4,
  parameter logic [15:0] VEND_ID   = 16'h5A5A,
  parameter logic [15:0] DEV_ID    = 16'hC0DE,
  parameter logic [7:0]  REV_ID    = 8'h03,
  parameter logic [15:0] CMD_WMASK = 16'h0547
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        io_req,
  input  logic                        io_we,
  input  logic [OFS_W-1:0]            io_ofs,
  input  logic [2:0]                  io_size,
  input  logic [WORD_W-1:0]           io_wdata,
  output logic [WORD_W-1:0]           io_rdata,
  output logic                        io_rvalid,
  output logic [N_SLOTS-1:0]          sl_wr,
  output logic [REG_W-1:0]            sl_reg,
  output logic [LANES-1:0]            sl_be,
  output logic [WORD_W-1:0]           sl_wdata,
  input  logic [WORD_W*N_SLOTS-1:0]   sl_rdata,
  input  logic [N_SLOTS-1:0]          sl_present,
  output logic [PIN_W*N_SLOTS-1:0]    sl_int_pin
);
  localparam int unsigned HI_W = OFS_W - 2;

  logic [HI_W-1:0]   ofs_hi;
  logic [1:0]        start;
  logic              in_addr, in_win;
  logic              acc_ok;
  logic [LANES-1:0]  acc_be, acc_span;
  logic [WORD_W-1:0] wlane;
  logic [WORD_W-1:0] addr_q;
  logic              addr_wr;
  logic              win_on;
  logic [DEV_W-1:0]  dev;
  logic [REG_W-1:0]  regn;
  logic              win_wr, br_wr, rd_req;
  logic [WORD_W-1:0] br_rdata;
  logic              slot_hit;
  logic [WORD_W-1:0] slot_val, win_val, sel_val, fmt_val;

  assign ofs_hi  = io_ofs[OFS_W-1:2];
  assign start   = io_ofs[1:0];
  assign in_addr = (ofs_hi == '0);
  assign in_win  = (ofs_hi == HI_W'(1));

  cfgp_lane_ctl u_lane (
    .start (start),
    .size  (io_size),
    .ok    (acc_ok),
    .be    (acc_be),
    .span  (acc_span)
  );

  assign wlane   = io_wdata << {start, 3'b000};
  assign addr_wr = io_req && io_we && in_addr && acc_ok;

  cfgp_addr_reg u_addr (
    .clk   (clk),
    .rst   (rst),
    .wr    (addr_wr),
    .be    (acc_be),
    .wdata (wlane),
    .q     (addr_q)
  );

  // address decode
  assign win_on = addr_q[EN_BIT] && (addr_q[BUS_LSB +: BUS_W] == '0);
  assign dev    = addr_q[DEV_LSB +: DEV_W];
  assign regn   = addr_q[REG_LSB +: REG_W];

  assign win_wr = io_req && io_we && in_win && acc_ok && win_on;
  assign br_wr  = win_wr && (dev == '0);
  assign rd_req = io_req && !io_we;

  cfgp_bridge_regs #(
    .VEND_ID   (VEND_ID),
    .DEV_ID    (DEV_ID),
    .REV_ID    (REV_ID),
    .CMD_WMASK (CMD_WMASK)
  ) u_bridge (
    .clk   (clk),
    .rst   (rst),
    .wr    (br_wr),
    .regn  (regn),
    .be    (acc_be),
    .wdata (wlane),
    .rdata (br_rdata)
  );

  // per-slot strobes and interrupt pin constants
  for (genvar i = 0; i < int'(N_SLOTS); i++) begin : g_slot
    assign sl_wr[i] = win_wr && (dev == DEV_W'(i + 1)) && sl_present[i];
    assign sl_int_pin[i*PIN_W +: PIN_W] = PIN_W'(i % 4);
  end

  assign sl_reg   = regn;
  assign sl_be    = acc_be;
  assign sl_wdata = wlane;

  always_comb begin
    slot_hit = 1'b0;
    slot_val = ALL_ONES;
    for (int i = 0; i < int'(N_SLOTS); i++) begin
      if (dev == DEV_W'(i + 1) && sl_present[i]) begin
        slot_hit = 1'b1;
        slot_val = sl_rdata[i*WORD_W +: WORD_W];
      end
    end
  end

  always_comb begin
    if (!win_on)         win_val = ALL_ONES;
    else if (dev == '0)  win_val = br_rdata;
    else if (slot_hit)   win_val = slot_val;
    else                 win_val = ALL_ONES;
  end

  always_comb begin
    if (in_addr)      sel_val = addr_q;
    else if (in_win)  sel_val = win_val;
    else              sel_val = ALL_ONES;
    fmt_val = acc_ok ? ((sel_val >> {start, 3'b000}) & lanes_to_bits(acc_span))
                     : ALL_ONES;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rvalid <= 1'b0;
      io_rdata  <= '0;
    end else begin
      io_rvalid <= rd_req;
      if (rd_req) io_rdata <= fmt_val;
    end
  end
endmodule

// File: rtl/cfgp_checker.sv
`timescale 1ns/1ps
module cfgp_checker #(
  parameter int unsigned N_SLOTS = 4,
  parameter int unsigned OFS_W   = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 io_req,
  input logic                 io_we,
  input logic [OFS_W-1:0]     io_ofs,
  input logic [2:0]           io_size,
  input logic [31:0]          io_rdata,
  input logic                 io_rvalid,
  input logic [N_SLOTS-1:0]   sl_wr,
  input logic [31:0]          addr_q
);
  logic [3:0] end_lane;
  logic       crossing, size_bad, is_read;

  assign end_lane = {2'b00, io_ofs[1:0]} + {1'b0, io_size};
  assign crossing = end_lane > 4'd4;
  assign size_bad = !(io_size == 3'd1 || io_size == 3'd2 || io_size == 3'd4);
  assign is_read  = io_req && !io_we;

  // R1: address register is clear on leaving reset
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> addr_q == 32'h0);

  // R12: one read response per read request, none otherwise
  p_rvalid_read_r12: assert property (@(posedge clk) disable iff (rst)
    is_read |=> io_rvalid);
  p_rvalid_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !is_read |=> !io_rvalid);

  // R5: lane-crossing reads return all ones
  p_cross_ones_r5: assert property (@(posedge clk) disable iff (rst)
    (is_read && crossing) |=> io_rdata == 32'hFFFF_FFFF);

  // R4: bad-size write to the address register keeps it
  p_bad_size_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (io_req && io_we && io_ofs[OFS_W-1:2] == '0 && size_bad) |=> $stable(addr_q));

  // R9: at most one slot strobe, only on a write to the window
  p_slot_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sl_wr));
  p_slot_src_r9: assert property (@(posedge clk) disable iff (rst)
    (sl_wr != '0) |-> (io_req && io_we && io_ofs[OFS_W-1:2] == 1));

  // R6: no strobe while the window is disabled or on another bus
  p_slot_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (!addr_q[31] || addr_q[23:16] != 8'h00) |-> sl_wr == '0);
endmodule

bind cfg_access_port cfgp_checker #(
  .N_SLOTS (N_SLOTS),
  .OFS_W   (OFS_W)
) u_cfgp_checker (
  .clk       (clk),
  .rst       (rst),
  .io_req    (io_req),
  .io_we     (io_we),
  .io_ofs    (io_ofs),
  .io_size   (io_size),
  .io_rdata  (io_rdata),
  .io_rvalid (io_rvalid),
  .sl_wr     (sl_wr),
  .addr_q    (addr_q)
);

// File: tb/test_cfg_access_port.sv
`timescale 1ns/1ps
module test_cfg_access_port;
  localparam int N = 4;
  localparam logic [15:0] VEND = 16'h5A5A;
  localparam logic [15:0] DEVI = 16'hC0DE;
  localparam logic [7:0]  REV  = 8'h03;
  localparam logic [15:0] CMDM = 16'h0547;
  localparam logic [N-1:0] PRESENT = 4'b1011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_req = 1'b0, io_we = 1'b0;
  logic [3:0] io_ofs = '0;
  logic [2:0] io_size = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic io_rvalid;
  logic [N-1:0] sl_wr;
  logic [5:0] sl_reg;
  logic [3:0] sl_be;
  logic [31:0] sl_wdata;
  logic [32*N-1:0] sl_rdata;
  logic [2*N-1:0] sl_int_pin;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  cfg_access_port #(
    .N_SLOTS(N), .OFS_W(4), .VEND_ID(VEND), .DEV_ID(DEVI),
    .REV_ID(REV), .CMD_WMASK(CMDM)
  ) i_cfg_access_port (
    .clk(clk), .rst(rst), .io_req(io_req), .io_we(io_we), .io_ofs(io_ofs),
    .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_rvalid(io_rvalid), .sl_wr(sl_wr), .sl_reg(sl_reg), .sl_be(sl_be),
    .sl_wdata(sl_wdata), .sl_rdata(sl_rdata), .sl_present(PRESENT),
    .sl_int_pin(sl_int_pin)
  );

  // behavioural endpoint register files driven by the block's strobes
  logic [31:0] dev_mem [N][64];
  always @(posedge clk)
    for (int i = 0; i < N; i++)
      if (sl_wr[i])
        for (int b = 0; b < 4; b++)
          if (sl_be[b]) dev_mem[i][sl_reg][b*8 +: 8] <= sl_wdata[b*8 +: 8];
  always_comb
    for (int i = 0; i < N; i++) sl_rdata[i*32 +: 32] = dev_mem[i][sl_reg];

  // reference model state
  logic [31:0] m_addr;
  logic [15:0] m_cmd;
  logic [31:0] m_br [64];
  logic [31:0] m_sl [N][64];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit en, int bus, int dv, int fn, int r);
    return {en, 7'b0, 8'(bus), 5'(dv), 3'(fn), 6'(r), 2'b00};
  endfunction

  function automatic logic [31:0] m_bridge(int r);
    case (r)
      0: return {DEVI, VEND};
      1: return {16'h0000, m_cmd};
      2: return {8'h06, 8'h00, 8'h00, REV};
      3: return 32'h0001_0000;
      default: return m_br[r];
    endcase
  endfunction

  function automatic logic [31:0] m_window();
    int dv, r;
    if (!m_addr[31] || m_addr[23:16] != 0) return 32'hFFFF_FFFF;
    dv = int'(m_addr[15:11]);
    r  = int'(m_addr[7:2]);
    if (dv == 0) return m_bridge(r);
    if (dv - 1 < N && PRESENT[dv-1]) return m_sl[dv-1][r];
    return 32'hFFFF_FFFF;
  endfunction

  function automatic bit m_ok(int ofs, int size);
    return (size == 1 || size == 2 || size == 4) && ((ofs % 4) + size <= 4);
  endfunction

  function automatic logic [31:0] m_read(int ofs, int size);
    logic [31:0] v, mask;
    if (ofs < 4)      v = m_addr;
    else if (ofs < 8) v = m_window();
    else              v = 32'hFFFF_FFFF;
    if (!m_ok(ofs, size)) return 32'hFFFF_FFFF;
    mask = (size == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * size)) - 32'h1);
    return (v >> (8 * (ofs % 4))) & mask;
  endfunction

  task automatic m_write(input int ofs, input int size, input logic [31:0] wd,
                         output logic [N-1:0] xwr, output logic [3:0] xbe,
                         output logic [31:0] xwd);
    int st, dv, r;
    xwr = '0; xbe = '0; xwd = '0;
    if (!m_ok(ofs, size) || ofs >= 8) return;
    st  = ofs % 4;
    xbe = 4'(((1 << size) - 1) << st);
    xwd = wd << (8 * st);
    if (ofs < 4) begin
      for (int b = 0; b < 4; b++) if (xbe[b]) m_addr[b*8 +: 8] = xwd[b*8 +: 8];
      return;
    end
    if (!m_addr[31] || m_addr[23:16] != 0) return;
    dv = int'(m_addr[15:11]);
    r  = int'(m_addr[7:2]);
    if (dv == 0) begin
      if (r == 1) begin
        for (int b = 0; b < 2; b++)
          if (xbe[b]) m_cmd[b*8 +: 8] = xwd[b*8 +: 8] & CMDM[b*8 +: 8];
      end else if (r >= 4) begin
        for (int b = 0; b < 4; b++) if (xbe[b]) m_br[r][b*8 +: 8] = xwd[b*8 +: 8];
      end
    end else if (dv - 1 < N && PRESENT[dv-1]) begin
      xwr[dv-1] = 1'b1;
      for (int b = 0; b < 4; b++) if (xbe[b]) m_sl[dv-1][r][b*8 +: 8] = xwd[b*8 +: 8];
    end
  endtask

  task automatic access(input bit we, input int ofs, input int size,
                        input logic [31:0] wd, input string req);
    logic [31:0] exp_rd;
    logic [N-1:0] xwr;
    logic [3:0] xbe;
    logic [31:0] xwd;
    logic [5:0] xreg;
    @(negedge clk);
    io_req = 1'b1; io_we = we; io_ofs = 4'(ofs); io_size = 3'(size); io_wdata = wd;
    xreg = m_addr[7:2];
    exp_rd = 32'h0; xwr = '0; xbe = '0; xwd = '0;
    if (!we) exp_rd = m_read(ofs, size);
    else     m_write(ofs, size, wd, xwr, xbe, xwd);
    #1;
    check(req, "slot strobe", 32'(sl_wr), 32'(xwr));
    if (xwr != '0) begin
      check(req, "slot byte enables", 32'(sl_be), 32'(xbe));
      check(req, "slot write data", sl_wdata, xwd);
      check(req, "slot register", 32'(sl_reg), 32'(xreg));
    end
    @(negedge clk);
    io_req = 1'b0; io_we = 1'b0;
    check("R12", "read valid", 32'(io_rvalid), 32'(!we));
    if (!we) check(req, "read data", io_rdata, exp_rd);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++)
      for (int r = 0; r < 64; r++) begin dev_mem[i][r] = '0; m_sl[i][r] = '0; end
    m_addr = '0; m_cmd = '0;
    repeat (4) @(negedge clk);
    check("R1", "rvalid in reset", 32'(io_rvalid), 32'h0);
    rst = 1'b0;
    // R1
    access(0, 0, 4, 0, "R1");
    access(0, 4, 4, 0, "R1");
    // R3: lane-wise address writes
    access(1, 1, 1, 32'h0000_00AB, "R3");
    access(0, 0, 4, 0, "R3");
    access(1, 2, 2, 32'h0000_1234, "R3");
    access(0, 0, 4, 0, "R3");
    access(1, 0, 4, 32'h7F3C_A5C8, "R3");
    access(0, 0, 4, 0, "R3");
    // R5: read lane extraction
    access(0, 1, 1, 0, "R5");
    access(0, 2, 2, 0, "R5");
    access(0, 3, 1, 0, "R5");
    access(0, 3, 2, 0, "R5");
    access(0, 0, 3, 0, "R5");
    access(0, 1, 4, 0, "R5");
    // R4: ignored writes
    access(1, 3, 2, 32'h0000_FFFF, "R4");
    access(1, 1, 3, 32'h00FF_FFFF, "R4");
    access(1, 0, 0, 32'hFFFF_FFFF, "R4");
    access(1, 2, 4, 32'hFFFF_FFFF, "R4");
    access(0, 0, 4, 0, "R4");
    // R2: offsets past the window
    access(0, 8, 4, 0, "R2");
    access(0, 13, 1, 0, "R2");
    access(1, 12, 4, 32'hDEAD_BEEF, "R2");
    access(1, 9, 1, 32'h0000_0011, "R2");
    access(0, 0, 4, 0, "R2");
    // R7: bridge identity words
    access(1, 0, 4, mk(1, 0, 0, 0, 0), "R7");
    access(0, 4, 4, 0, "R7");
    access(1, 0, 1, mk(1, 0, 0, 0, 2), "R7");
    access(0, 4, 4, 0, "R7");
    access(0, 7, 1, 0, "R7");
    access(1, 4, 4, 32'hFFFF_FFFF, "R7");
    access(0, 4, 4, 0, "R7");
    access(1, 0, 1, mk(1, 0, 0, 0, 3), "R7");
    access(0, 4, 4, 0, "R7");
    access(0, 6, 2, 0, "R7");
    access(1, 0, 1, mk(1, 0, 0, 0, 0), "R7");
    access(1, 4, 4, 32'h1111_2222, "R7");
    access(0, 4, 4, 0, "R7");
    // R8: command register and storage dwords
    access(1, 0, 1, mk(1, 0, 0, 0, 1), "R8");
    access(1, 4, 4, 32'hFFFF_FFFF, "R8");
    access(0, 4, 4, 0, "R8");
    access(1, 5, 1, 32'h0000_0000, "R8");
    access(0, 4, 4, 0, "R8");
    access(1, 0, 1, mk(1, 0, 0, 0, 10), "R8");
    access(1, 4, 4, 32'h1122_3344, "R8");
    access(1, 7, 1, 32'h0000_0099, "R8");
    access(0, 4, 4, 0, "R8");
    access(1, 0, 1, mk(1, 0, 0, 0, 63), "R8");
    access(1, 6, 2, 32'h0000_ABCD, "R8");
    access(0, 6, 2, 0, "R8");
    // R9: slot routing
    access(1, 0, 4, mk(1, 0, 1, 0, 5), "R9");
    access(1, 4, 4, 32'hCAFE_F00D, "R9");
    access(0, 4, 4, 0, "R9");
    access(1, 6, 2, 32'h0000_BEEF, "R9");
    access(0, 4, 4, 0, "R9");
    access(1, 0, 4, mk(1, 0, 2, 0, 5), "R9");
    access(1, 4, 4, 32'h0BAD_0BAD, "R9");
    access(0, 4, 4, 0, "R9");
    access(1, 0, 4, mk(1, 0, 1, 0, 5), "R9");
    access(0, 4, 4, 0, "R9");
    access(1, 0, 4, mk(1, 0, 4, 0, 0), "R9");
    access(1, 5, 1, 32'h0000_0077, "R9");
    access(0, 4, 4, 0, "R9");
    // R10: empty and out-of-range slots
    access(1, 0, 4, mk(1, 0, 3, 0, 5), "R10");
    access(1, 4, 4, 32'h1234_5678, "R10");
    access(0, 4, 4, 0, "R10");
    access(1, 0, 4, mk(1, 0, 9, 0, 5), "R10");
    access(1, 4, 4, 32'h1234_5678, "R10");
    access(0, 4, 4, 0, "R10");
    // R6: disabled window and other bus
    access(1, 0, 4, mk(0, 0, 1, 0, 5), "R6");
    access(0, 4, 4, 0, "R6");
    access(1, 4, 4, 32'h5555_5555, "R6");
    access(1, 0, 4, mk(1, 1, 1, 0, 5), "R6");
    access(0, 4, 4, 0, "R6");
    access(1, 4, 4, 32'h6666_6666, "R6");
    access(1, 0, 4, mk(1, 0, 1, 0, 5), "R6");
    access(0, 4, 4, 0, "R6");
    // R11: function number ignored
    access(1, 0, 4, mk(1, 0, 1, 5, 5), "R11");
    access(0, 4, 4, 0, "R11");
    access(1, 0, 4, mk(1, 0, 2, 7, 6), "R11");
    access(1, 4, 4, 32'hFACE_0001, "R11");
    access(1, 0, 4, mk(1, 0, 2, 0, 6), "R11");
    access(0, 4, 4, 0, "R11");
    // R12: idle cycles give no read valid
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R12", "idle read valid", 32'(io_rvalid), 32'h0);
    end
    // R13: interrupt pin per slot
    for (int i = 0; i < N; i++)
      check("R13", "interrupt pin", 32'(sl_int_pin[i*2 +: 2]), 32'(i % 4));
    finish_run();
  end
endmodule